// File: doc/BRIEF.md
# Channel Enable and Length Counter Status Unit

This unit keeps the on/off state and the note-length countdown for four tone channels: two square-wave channels, one triangle channel and one noise channel. A processor-side bus writes a channel-enable register and a length-load register for each channel, and reads a packed status byte back. A frame sequencer elsewhere in the chip sends a half-frame tick. On that tick every running length counter counts down unless its channel's halt bit is asserted. The per-channel "still sounding" flags go out to gate the waveform generators, which are not part of this unit.

The fifth enable bit goes to a delta-modulation sample engine that sits next to this unit. That engine returns a bytes-remaining flag and an interrupt flag, and the frame sequencer supplies a frame interrupt flag. The status byte packs all of these together. Two single-cycle clear strobes go back out: one to the frame sequencer after a status read, and one to the sample engine after any write to the enable register.

Top module: `chan_status_unit`

## Requirements
- R1: After reset, every channel enable is 0, every length counter is 0, `len_active` is 0, `dm_enable` is 0, and `rd_valid`, `frame_irq_clr` and `dm_irq_clr` are all low.
- R2: A write to address 0x4015 sets the channel enables from data bits 0..3 (bit 0 square 1, bit 1 square 2, bit 2 triangle, bit 3 noise) and sets `dm_enable` from data bit 4. All of these take effect at the clock edge that accepts the write.
- R3: A write to a length-load address (0x4003 for square 1, 0x4007 for square 2, 0x400B for triangle, 0x400F for noise) while that channel is enabled loads its counter from a fixed 32-entry table. The table is indexed by data bits 7..3, and its entries for indices 0..31 are 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30.
- R4: A length-load write to a channel that is disabled leaves its counter unchanged.
- R5: A write to 0x4015 with a channel's enable bit clear forces that channel's counter to 0 at the same edge.
- R6: On a half-frame tick, a nonzero counter whose halt bit is low decrements by one. `len_active[i]` is high exactly while counter i is nonzero.
- R7: A counter whose halt bit is high holds its value on a half-frame tick. A counter at zero stays at zero.
- R8: When a length load and a half-frame tick arrive in the same cycle, the loaded value wins and is not decremented in that cycle.
- R9: A read strobe to 0x4015 returns the status byte on `rd_data` the cycle after the strobe, with `rd_valid` high. The byte has bits 0..3 set to the channels' counter-nonzero flags, bit 4 set to `dm_bytes_left`, bit 5 set to 0, bit 6 set to `frame_irq` and bit 7 set to `dm_irq`, all sampled in the cycle of the strobe.
- R10: A status read raises `frame_irq_clr` for exactly one cycle, in the same cycle as `rd_valid`, so the byte already holds the flag value from before the clear.
- R11: Any write to 0x4015 raises `dm_irq_clr` for exactly one cycle, the cycle after the write.
- R12: Writes to other addresses (for example 0x4002 or 0x4017) change no enable, no counter and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| half_tick | input | 1 | Half-frame tick from the frame sequencer |
| len_halt | input | 4 | Per-channel halt bits |
| dm_bytes_left | input | 1 | Sample engine has bytes remaining |
| dm_irq | input | 1 | Sample engine interrupt flag |
| frame_irq | input | 1 | Frame sequencer interrupt flag |
| rd_data | output | 8 | Captured status byte |
| rd_valid | output | 1 | rd_data is valid this cycle |
| len_active | output | 4 | Per-channel counter-nonzero flags |
| dm_enable | output | 1 | Enable to the sample engine |
| frame_irq_clr | output | 1 | Clear pulse toward the frame interrupt flag |
| dm_irq_clr | output | 1 | Clear pulse toward the sample engine interrupt flag |

## Verification
Enable, load, disable and decrement all change their registers at the edge that accepts the strobe. `len_active` and `dm_enable` therefore show the new value one clock after the strobe is driven. `rd_data`, `rd_valid`, `frame_irq_clr` and `dm_irq_clr` are registered pulses that are also due one clock after the strobe and last a single cycle. The bench drives every strobe on a falling edge, removes it on the next falling edge, and samples at that falling edge. Each result is therefore read in the cycle it is due, and pulse checks confirm that the strobe has dropped one cycle later. Exact counter values are checked by counting half-frame ticks until the active flag falls.

// File: rtl/csu_pkg.sv
package csu_pkg;

  localparam int CH_N  = 4;
  localparam int LEN_W = 8;
  localparam int IDX_W = 5;
  localparam int ADR_W = 16;

  typedef enum logic [1:0] {
    CH_SQ1 = 2'd0,
    CH_SQ2 = 2'd1,
    CH_TRI = 2'd2,
    CH_NOI = 2'd3
  } chan_e;

  // Length values indexed by write data bits 7..3.
  function automatic logic [LEN_W-1:0] len_lookup(input logic [IDX_W-1:0] idx);
    logic [LEN_W-1:0] v;
    case (idx)
      5'd0:  v = 8'd10;
      5'd1:  v = 8'd254;
      5'd2:  v = 8'd20;
      5'd3:  v = 8'd2;
      5'd4:  v = 8'd40;
      5'd5:  v = 8'd4;
      5'd6:  v = 8'd80;
      5'd7:  v = 8'd6;
      5'd8:  v = 8'd160;
      5'd9:  v = 8'd8;
      5'd10: v = 8'd60;
      5'd11: v = 8'd10;
      5'd12: v = 8'd14;
      5'd13: v = 8'd12;
      5'd14: v = 8'd26;
      5'd15: v = 8'd14;
      5'd16: v = 8'd12;
      5'd17: v = 8'd16;
      5'd18: v = 8'd24;
      5'd19: v = 8'd18;
      5'd20: v = 8'd48;
      5'd21: v = 8'd20;
      5'd22: v = 8'd96;
      5'd23: v = 8'd22;
      5'd24: v = 8'd192;
      5'd25: v = 8'd24;
      5'd26: v = 8'd72;
      5'd27: v = 8'd26;
      5'd28: v = 8'd16;
      5'd29: v = 8'd28;
      5'd30: v = 8'd32;
      default: v = 8'd30;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
#(
  parameter logic [ADR_W-1:0] ENA_ADDR    = 16'h4015,
  parameter logic [ADR_W-1:0] LEN_BASE    = 16'h4003,
  parameter int               LEN_STRIDE  = 4
) (
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [ADR_W-1:0] bus_addr,
  output logic [CH_N-1:0]  ld_hit,
  output logic             ena_wr,
  output logic             stat_rd
);

  genvar g;
  generate
    for (g = 0; g < CH_N; g++) begin : g_ld
      localparam logic [ADR_W-1:0] ADDR_G = LEN_BASE + ADR_W'(g * LEN_STRIDE);
      assign ld_hit[g] = bus_wr && (bus_addr == ADDR_G);
    end
  endgenerate

  always_comb begin
    ena_wr  = bus_wr && (bus_addr == ENA_ADDR);
    stat_rd = bus_rd && (bus_addr == ENA_ADDR);
  end

endmodule

// File: rtl/csu_len_ctr.sv
module csu_len_ctr
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             ld_hit,
  input  logic [LEN_W-1:0] ld_val,
  input  logic             ena_wr,
  input  logic             new_en,
  input  logic             half_tick,
  input  logic             halt,
  output logic             active
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             zero_now, load_now, dec_now;

  always_comb begin
    zero_now = ena_wr && !new_en;
    load_now = ld_hit && ch_en;
    dec_now  = half_tick && !halt && (cnt_q != '0);
    cnt_ce   = zero_now || load_now || dec_now;
    cnt_d    = cnt_q;
    if (zero_now)      cnt_d = '0;
    else if (load_now) cnt_d = ld_val;
    else if (dec_now)  cnt_d = cnt_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R5: a disable write clears the counter at that edge
  a_r5_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && !new_en) |=> (cnt_q == '0));

  // R4: a load to a disabled channel changes nothing
  a_r4_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && !ch_en && !half_tick && !ena_wr) |=> $stable(cnt_q));

  // R6: a running, unhalted counter steps down by one
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !halt && (cnt_q != '0) && !ld_hit && !ena_wr)
      |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

  // R7: a halted counter holds its value on a tick
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && halt && !ld_hit && !ena_wr) |=> $stable(cnt_q));

  // R8: a load in the same cycle as a tick lands undecremented
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && ch_en && half_tick && !ena_wr) |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/csu_status.sv
module csu_status
  import csu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            ena_wr,
  input  logic [CH_N-1:0] len_active,
  input  logic            dm_bytes_left,
  input  logic            frame_irq,
  input  logic            dm_irq,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  output logic            frame_irq_clr,
  output logic            dm_irq_clr
);

  logic [7:0] data_q, data_d;
  logic       vld_q, vld_d;
  logic       fclr_q, fclr_d;
  logic       dclr_q, dclr_d;

  always_comb begin
    data_d = {dm_irq, frame_irq, 1'b0, dm_bytes_left, len_active};
    vld_d  = stat_rd;
    fclr_d = stat_rd;
    dclr_d = ena_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (stat_rd) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      fclr_q <= 1'b0;
      dclr_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      fclr_q <= fclr_d;
      dclr_q <= dclr_d;
    end
  end

  assign rd_data       = data_q;
  assign rd_valid      = vld_q;
  assign frame_irq_clr = fclr_q;
  assign dm_irq_clr    = dclr_q;

  // R10: a read yields a clear pulse together with the data
  a_r10_clear_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (frame_irq_clr && rd_valid));

  // R10: the clear pulse lasts one cycle unless a new read follows
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq_clr && !stat_rd) |=> !frame_irq_clr);

  // R11: an enable-register write yields the interrupt clear pulse
  a_r11_dm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> dm_irq_clr);

  // R9: the captured frame flag matches its value at the strobe
  a_r9_frame_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (rd_data[6] == $past(frame_irq)));

endmodule

// File: rtl/chan_status_unit.sv
module chan_status_unit
  import csu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        half_tick,
  input  logic [3:0]  len_halt,
  input  logic        dm_bytes_left,
  input  logic        dm_irq,
  input  logic        frame_irq,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [3:0]  len_active,
  output logic        dm_enable,
  output logic        frame_irq_clr,
  output logic        dm_irq_clr
);

  localparam int DM_BIT = CH_N;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [CH_N-1:0]   ld_hit;
  logic              ena_wr, stat_rd;
  logic [CH_N-1:0]   ch_en_q, ch_en_d;
  logic              dm_en_q, dm_en_d;
  logic              en_ce;
  logic [LEN_W-1:0]  ld_val;

  csu_decode u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .ld_hit  (ld_hit),
    .ena_wr  (ena_wr),
    .stat_rd (stat_rd)
  );

  always_comb begin
    en_ce   = ena_wr;
    ch_en_d = bus_wdata[CH_N-1:0];
    dm_en_d = bus_wdata[DM_BIT];
    ld_val  = len_lookup(bus_wdata[7 -: IDX_W]);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ch_en_q <= '0;
      dm_en_q <= 1'b0;
    end else if (en_ce) begin
      ch_en_q <= ch_en_d;
      dm_en_q <= dm_en_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < CH_N; g++) begin : g_ch
      csu_len_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .ch_en    (ch_en_q[g]),
        .ld_hit   (ld_hit[g]),
        .ld_val   (ld_val),
        .ena_wr   (ena_wr),
        .new_en   (bus_wdata[g]),
        .half_tick(half_tick),
        .halt     (len_halt[g]),
        .active   (len_active[g])
      );
    end
  endgenerate

  csu_status u_st (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .stat_rd      (stat_rd),
    .ena_wr       (ena_wr),
    .len_active   (len_active),
    .dm_bytes_left(dm_bytes_left),
    .frame_irq    (frame_irq),
    .dm_irq       (dm_irq),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .frame_irq_clr(frame_irq_clr),
    .dm_irq_clr   (dm_irq_clr)
  );

  assign dm_enable = dm_en_q;

  // R2: the sample-engine enable follows data bit 4 of an enable write
  a_r2_dm_enable: assert property (@(posedge clk) disable iff (!rst_i_n)
    ena_wr |=> (dm_enable == $past(bus_wdata[DM_BIT])));

  // R1: no activity while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_i_n |-> (len_active == '0 && !rd_valid && !dm_enable));

endmodule

// File: tb/test_chan_status_unit.sv
module test_chan_status_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        half_tick = 1'b0;
  logic [3:0]  len_halt = '0;
  logic        dm_bytes_left = 1'b0;
  logic        dm_irq = 1'b0;
  logic        frame_irq = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [3:0]  len_active;
  logic        dm_enable;
  logic        frame_irq_clr;
  logic        dm_irq_clr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chan_status_unit i_chan_status_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .half_tick(half_tick),
    .len_halt(len_halt), .dm_bytes_left(dm_bytes_left), .dm_irq(dm_irq),
    .frame_irq(frame_irq), .rd_data(rd_data), .rd_valid(rd_valid),
    .len_active(len_active), .dm_enable(dm_enable),
    .frame_irq_clr(frame_irq_clr), .dm_irq_clr(dm_irq_clr)
  );

  // Table vectors: length index and expected length (R3)
  localparam int NV = 8;
  localparam logic [4:0] V_IDX [NV] = '{5'd0, 5'd1, 5'd4, 5'd8, 5'd12, 5'd18, 5'd24, 5'd29};
  localparam int         V_LEN [NV] = '{10, 254, 40, 160, 14, 24, 192, 28};
  localparam logic [15:0] LD_ADDR [4] = '{16'h4003, 16'h4007, 16'h400B, 16'h400F};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle; returns at the falling edge after the accepting edge.
  task automatic cyc(input logic wr, input logic rd, input logic [15:0] a,
                     input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; half_tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; half_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 active", len_active, 4'h0);
    check("R1 dm_enable", dm_enable, 1'b0);
    check("R1 pulses", {rd_valid, frame_irq_clr, dm_irq_clr}, 3'b000);
    cyc(1'b0, 1'b1, 16'h4015, 8'h00, 1'b0);
    check("R1 status after reset", rd_data, 8'h00);

    // R4: load ignored while disabled
    cyc(1'b1, 1'b0, 16'h4003, 8'h08, 1'b0);
    check("R4 disabled load", len_active, 4'h0);

    // R2 / R11: enable write
    cyc(1'b1, 1'b0, 16'h4015, 8'h1F, 1'b0);
    check("R2 dm_enable set", dm_enable, 1'b1);
    check("R11 dm_irq_clr pulse", dm_irq_clr, 1'b1);
    @(negedge clk);
    check("R11 pulse one cycle", dm_irq_clr, 1'b0);

    // R3 / R6: table walk
    for (int i = 0; i < NV; i++) begin
      int ch;
      ch = i % 4;
      cyc(1'b1, 1'b0, LD_ADDR[ch], {V_IDX[i], 3'b000}, 1'b0);
      check("R3 loaded active", len_active[ch], 1'b1);
      ticks(V_LEN[i] - 1);
      check("R6 active before last tick", len_active[ch], 1'b1);
      ticks(1);
      check("R3 R6 expires at table length", len_active[ch], 1'b0);
    end

    // R7: halt holds, zero stays zero
    len_halt = 4'b0010;
    cyc(1'b1, 1'b0, 16'h4007, 8'h18, 1'b0);   // index 3 -> 2
    ticks(5);
    check("R7 halted holds", len_active[1], 1'b1);
    len_halt = 4'b0000;
    ticks(2);
    check("R7 released expires", len_active[1], 1'b0);
    ticks(1);
    check("R7 zero stays zero", len_active[1], 1'b0);

    // R8: load beats a simultaneous tick
    cyc(1'b1, 1'b0, 16'h400F, 8'h18, 1'b1);   // index 3 -> 2
    ticks(1);
    check("R8 load not decremented", len_active[3], 1'b1);
    ticks(1);
    check("R8 expires after two", len_active[3], 1'b0);

    // R5: disable forces zero
    cyc(1'b1, 1'b0, 16'h400B, 8'h08, 1'b0);   // index 1 -> 254
    check("R5 triangle running", len_active[2], 1'b1);
    cyc(1'b1, 1'b0, 16'h4015, 8'h0B, 1'b0);
    check("R5 disable clears", len_active[2], 1'b0);
    check("R2 dm_enable cleared", dm_enable, 1'b0);

    // R12: unrelated writes have no effect
    cyc(1'b1, 1'b0, 16'h4003, 8'h08, 1'b0);   // square 1 -> 254
    cyc(1'b1, 1'b0, 16'h4017, 8'h00, 1'b0);
    check("R12 0x4017 no clear pulse", dm_irq_clr, 1'b0);
    cyc(1'b1, 1'b0, 16'h4002, 8'h00, 1'b0);
    check("R12 active unchanged", len_active, 4'b0001);
    check("R12 dm_enable unchanged", dm_enable, 1'b0);

    // R9 / R10: status read with flags
    frame_irq = 1'b1; dm_irq = 1'b1; dm_bytes_left = 1'b1;
    cyc(1'b0, 1'b1, 16'h4015, 8'h00, 1'b0);
    check("R9 status byte", rd_data, 8'hD1);
    check("R9 rd_valid", rd_valid, 1'b1);
    check("R10 frame clear with data", frame_irq_clr, 1'b1);
    frame_irq = 1'b0;
    @(negedge clk);
    check("R10 pulse one cycle", {frame_irq_clr, rd_valid}, 2'b00);
    dm_irq = 1'b0;
    cyc(1'b0, 1'b1, 16'h4015, 8'h00, 1'b0);
    check("R9 status after clear", rd_data, 8'h11);

    finish_run();
  end

endmodule